// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block sits on the write side of a NOR-style flash controller model. It watches single-cycle bus writes (address plus one data byte) and follows the multi-cycle unlock grammar that guards every destructive operation. When a sequence completes, it issues a one-cycle start pulse to a separate embedded-operation engine, together with the captured address and data. A program, a whole-device erase or a sector erase can be started this way. Any cycle that does not fit the grammar quietly drops the decoder back to plain array reads.

Two side modes are tracked. An identification mode lets reads return a maker code, a part code and the protect flag of the addressed sector. A fast-program mode cuts each program down to two writes. While the engine reports busy, the decoder reports status-read mode and ignores all writes. The single exception is a suspend request written while a sector erase runs.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, read_mode is 00 (array), id_data is 00h and no start or suspend pulse is high.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h followed by any address/data produce one start_prog pulse on the cycle after the last write, with op_addr/op_data equal to that write. The decoder then returns to array mode.
- R3: Writing two unlocks, 80h@555h, two unlocks and then 10h@555h pulses start_chip. Ending instead with 30h at any address pulses start_sect, with op_addr equal to that address.
- R4: The 555h and 2AAh matches use only the low 11 address bits. Upper address bits do not matter for command cycles.
- R5: A wrong address or data value at any step of a sequence returns the decoder to array mode. The rest of that sequence then starts nothing, and a fresh complete sequence works afterwards.
- R6: An F0h write between the cycles of a sequence, before its final cycle, returns the decoder to array mode with nothing started.
- R7: Two unlocks plus 90h@555h set read_mode to 01. id_data then gives MFR_CODE for id_sel 0, DEV_CODE for id_sel 1, 01h/00h from sect_prot for id_sel 2, and 00h for id_sel 3. Any write other than F0h keeps this mode, and F0h leaves it. Outside this mode id_data is 00h.
- R8: Two unlocks plus 20h@555h enter fast-program mode. In this mode, A0h at any address followed by address/data pulses start_prog, and the mode is kept afterwards. Every other write, including F0h and erase commands, is ignored.
- R9: In fast-program mode, 90h followed by 00h (any addresses) exits to array mode. 90h followed by any other value stays in fast-program mode.
- R10: While eng_busy is high, read_mode is 10 and writes start nothing. Sequence state and mode are kept unchanged through the busy period.
- R11: A B0h write while busy with a sector erase pulses suspend_req for one cycle. During a program or a chip erase, B0h has no effect.
- R12: Start pulses last one cycle, and at most one of start_prog, start_chip and start_sect is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address (word) |
| wr_data | input | 8 | Write data byte |
| eng_busy | input | 1 | Embedded engine running |
| id_sel | input | 2 | Identification read offset |
| sect_prot | input | 1 | Protect flag of the addressed sector |
| start_prog | output | 1 | Program start pulse |
| start_chip | output | 1 | Whole-device erase start pulse |
| start_sect | output | 1 | Sector erase start pulse |
| suspend_req | output | 1 | Erase suspend pulse |
| op_addr | output | ADDR_W | Captured address for the started operation |
| op_data | output | 8 | Captured data for the started operation |
| read_mode | output | 2 | 00 array, 01 identification, 10 status |
| id_data | output | 8 | Identification read data |

## Verification
The hardest case to reach is a partly entered sequence, or a side mode, that survives a busy period. The decoder must freeze its state while the engine runs, not fall back to array mode. The bench gets there in three ways. It raises busy right after the first two unlock cycles, feeds junk writes, and then finishes the sequence to see a program start. It raises busy inside identification mode and feeds an F0h write, then checks that the mode is still there once busy drops. Finally, it checks that a suspend request appears only when the running operation is a sector erase.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    typedef enum logic [3:0] {
        ST_ARRAY,
        ST_UNL1,
        ST_UNL2,
        ST_PGM,
        ST_ERS0,
        ST_ERS1,
        ST_ERS2,
        ST_AUTO,
        ST_BYP,
        ST_BYP_PGM,
        ST_BYP_EXIT
    } seq_state_e;

    localparam logic [7:0] C_UNL_A = 8'hAA;
    localparam logic [7:0] C_UNL_B = 8'h55;
    localparam logic [7:0] C_PGM   = 8'hA0;
    localparam logic [7:0] C_ERS   = 8'h80;
    localparam logic [7:0] C_CHIP  = 8'h10;
    localparam logic [7:0] C_SECT  = 8'h30;
    localparam logic [7:0] C_AUTO  = 8'h90;
    localparam logic [7:0] C_BYP   = 8'h20;
    localparam logic [7:0] C_RST   = 8'hF0;
    localparam logic [7:0] C_SUSP  = 8'hB0;
    localparam logic [7:0] C_BEXIT = 8'h00;

    localparam logic [1:0] RM_ARRAY  = 2'b00;
    localparam logic [1:0] RM_AUTO   = 2'b01;
    localparam logic [1:0] RM_STATUS = 2'b10;

endpackage

// File: rtl/nor_cmd_addr_match.sv
module nor_cmd_addr_match #(
    parameter int ADDR_W  = 19,
    parameter int MATCH_W = 11
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_555,
    output logic              hit_2aa
);
    localparam logic [MATCH_W-1:0] K_555 = MATCH_W'(12'h555);
    localparam logic [MATCH_W-1:0] K_2AA = MATCH_W'(12'h2AA);

    logic [MATCH_W-1:0] low;

    generate
        if (MATCH_W >= ADDR_W) begin : g_full
            assign low = MATCH_W'(addr);
        end else begin : g_part
            assign low = addr[MATCH_W-1:0];
        end
    endgenerate

    assign hit_555 = (low == K_555);
    assign hit_2aa = (low == K_2AA);
endmodule

// File: rtl/nor_cmd_idmux.sv
module nor_cmd_idmux #(
    parameter logic [7:0] MFR_CODE = 8'h37,
    parameter logic [7:0] DEV_CODE = 8'h1A
) (
    input  logic       auto_on,
    input  logic [1:0] id_sel,
    input  logic       sect_prot,
    output logic [7:0] id_data
);
    always_comb begin
        id_data = 8'h00;
        if (auto_on) begin
            case (id_sel)
                2'd0:    id_data = MFR_CODE;
                2'd1:    id_data = DEV_CODE;
                2'd2:    id_data = {7'd0, sect_prot};
                default: id_data = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              hit_555,
    input  logic              hit_2aa,
    input  logic              eng_busy,
    output logic              start_prog,
    output logic              start_chip,
    output logic              start_sect,
    output logic              suspend_req,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic [1:0]        read_mode,
    output logic              auto_on
);
    typedef struct packed {
        seq_state_e        st;
        logic              erasing;
        logic              go_pgm;
        logic              go_chip;
        logic              go_sect;
        logic              susp;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } seq_regs_t;

    seq_regs_t q, d;

    always_comb begin
        d         = q;
        d.go_pgm  = 1'b0;
        d.go_chip = 1'b0;
        d.go_sect = 1'b0;
        d.susp    = 1'b0;
        if (eng_busy) begin
            if (wr_en && wr_data == C_SUSP && q.erasing) begin
                d.susp = 1'b1;
            end
        end else begin
            d.erasing = 1'b0;
            if (wr_en) begin
                case (q.st)
                    ST_ARRAY: begin
                        if (hit_555 && wr_data == C_UNL_A) d.st = ST_UNL1;
                    end
                    ST_UNL1: begin
                        d.st = (hit_2aa && wr_data == C_UNL_B) ? ST_UNL2 : ST_ARRAY;
                    end
                    ST_UNL2: begin
                        d.st = ST_ARRAY;
                        if (hit_555) begin
                            case (wr_data)
                                C_PGM:   d.st = ST_PGM;
                                C_ERS:   d.st = ST_ERS0;
                                C_AUTO:  d.st = ST_AUTO;
                                C_BYP:   d.st = ST_BYP;
                                default: d.st = ST_ARRAY;
                            endcase
                        end
                    end
                    ST_PGM: begin
                        d.st     = ST_ARRAY;
                        d.go_pgm = 1'b1;
                        d.addr   = wr_addr;
                        d.data   = wr_data;
                    end
                    ST_ERS0: begin
                        d.st = (hit_555 && wr_data == C_UNL_A) ? ST_ERS1 : ST_ARRAY;
                    end
                    ST_ERS1: begin
                        d.st = (hit_2aa && wr_data == C_UNL_B) ? ST_ERS2 : ST_ARRAY;
                    end
                    ST_ERS2: begin
                        d.st = ST_ARRAY;
                        if (hit_555 && wr_data == C_CHIP) begin
                            d.go_chip = 1'b1;
                            d.addr    = wr_addr;
                            d.data    = wr_data;
                        end else if (wr_data == C_SECT) begin
                            d.go_sect = 1'b1;
                            d.erasing = 1'b1;
                            d.addr    = wr_addr;
                            d.data    = wr_data;
                        end
                    end
                    ST_AUTO: begin
                        if (wr_data == C_RST) d.st = ST_ARRAY;
                    end
                    ST_BYP: begin
                        if (wr_data == C_PGM)       d.st = ST_BYP_PGM;
                        else if (wr_data == C_AUTO) d.st = ST_BYP_EXIT;
                    end
                    ST_BYP_PGM: begin
                        d.st     = ST_BYP;
                        d.go_pgm = 1'b1;
                        d.addr   = wr_addr;
                        d.data   = wr_data;
                    end
                    ST_BYP_EXIT: begin
                        d.st = (wr_data == C_BEXIT) ? ST_ARRAY : ST_BYP;
                    end
                    default: d.st = ST_ARRAY;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign start_prog  = q.go_pgm;
    assign start_chip  = q.go_chip;
    assign start_sect  = q.go_sect;
    assign suspend_req = q.susp;
    assign op_addr     = q.addr;
    assign op_data     = q.data;
    assign auto_on     = (q.st == ST_AUTO) && !eng_busy;
    assign read_mode   = eng_busy ? RM_STATUS : ((q.st == ST_AUTO) ? RM_AUTO : RM_ARRAY);
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder #(
    parameter int          ADDR_W   = 19,
    parameter int          MATCH_W  = 11,
    parameter logic [7:0]  MFR_CODE = 8'h37,
    parameter logic [7:0]  DEV_CODE = 8'h1A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              eng_busy,
    input  logic [1:0]        id_sel,
    input  logic              sect_prot,
    output logic              start_prog,
    output logic              start_chip,
    output logic              start_sect,
    output logic              suspend_req,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic [1:0]        read_mode,
    output logic [7:0]        id_data
);
    logic hit_555, hit_2aa, auto_on;

    nor_cmd_addr_match #(.ADDR_W(ADDR_W), .MATCH_W(MATCH_W)) u_match (
        .addr    (wr_addr),
        .hit_555 (hit_555),
        .hit_2aa (hit_2aa)
    );

    nor_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .hit_555     (hit_555),
        .hit_2aa     (hit_2aa),
        .eng_busy    (eng_busy),
        .start_prog  (start_prog),
        .start_chip  (start_chip),
        .start_sect  (start_sect),
        .suspend_req (suspend_req),
        .op_addr     (op_addr),
        .op_data     (op_data),
        .read_mode   (read_mode),
        .auto_on     (auto_on)
    );

    nor_cmd_idmux #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
        .auto_on   (auto_on),
        .id_sel    (id_sel),
        .sect_prot (sect_prot),
        .id_data   (id_data)
    );
endmodule

// File: rtl/nor_cmd_decoder_chk.sv
module nor_cmd_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       eng_busy,
    input logic       start_prog,
    input logic       start_chip,
    input logic       start_sect,
    input logic       suspend_req,
    input logic [1:0] read_mode,
    input logic [7:0] id_data
);
    a_r12_onehot_start: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_prog, start_chip, start_sect}));

    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (start_prog || start_chip || start_sect) |=> !(start_prog || start_chip || start_sect));

    a_r10_busy_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |=> !(start_prog || start_chip || start_sect));

    a_r11_suspend_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_req |-> $past(eng_busy));

    a_r11_suspend_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_req |=> !suspend_req);

    a_r7_id_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (read_mode != 2'b01) |-> (id_data == 8'h00));
endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .eng_busy    (eng_busy),
    .start_prog  (start_prog),
    .start_chip  (start_chip),
    .start_sect  (start_sect),
    .suspend_req (suspend_req),
    .read_mode   (read_mode),
    .id_data     (id_data)
);

// File: tb/nor_cmd_decoder_test.sv
`timescale 1ns/1ps
module nor_cmd_decoder_test;
    localparam int AW = 19;
    localparam logic [7:0] MFR = 8'h37;
    localparam logic [7:0] DEV = 8'h1A;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          eng_busy = 1'b0;
    logic [1:0]    id_sel = '0;
    logic          sect_prot = 1'b0;
    logic          start_prog, start_chip, start_sect, suspend_req;
    logic [AW-1:0] op_addr;
    logic [7:0]    op_data, id_data;
    logic [1:0]    read_mode;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    nor_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .eng_busy(eng_busy), .id_sel(id_sel), .sect_prot(sect_prot),
        .start_prog(start_prog), .start_chip(start_chip), .start_sect(start_sect),
        .suspend_req(suspend_req), .op_addr(op_addr), .op_data(op_data),
        .read_mode(read_mode), .id_data(id_data)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic unlock();
        wr(19'h00555, 8'hAA);
        wr(19'h002AA, 8'h55);
    endtask

    task automatic no_start(input string tag);
        check(tag, {29'd0, start_prog, start_chip, start_sect}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R1 reset state
        check("R1 read_mode", read_mode, 0);
        check("R1 id_data", id_data, 0);
        no_start("R1 starts");
        check("R1 suspend", suspend_req, 0);

        // R2 standard program, several patterns
        for (int i = 0; i < 4; i++) begin
            logic [AW-1:0] pa = 19'h12340 + AW'(i * 19'h1111);
            logic [7:0]    pd = 8'h3C ^ 8'(i * 8'h29);
            unlock();
            wr(19'h00555, 8'hA0);
            wr(pa, pd);
            check("R2 start_prog", start_prog, 1);
            check("R2 op_addr", op_addr, pa);
            check("R2 op_data", op_data, pd);
            idle();
            check("R12 pulse ends", start_prog, 0);
            check("R2 back to array", read_mode, 0);
        end

        // R3 chip erase
        unlock(); wr(19'h00555, 8'h80); unlock(); wr(19'h00555, 8'h10);
        check("R3 start_chip", start_chip, 1);
        check("R12 onehot chip", {start_prog, start_sect}, 0);
        idle();
        check("R12 chip pulse ends", start_chip, 0);

        // R3 sector erase across all sector bases
        for (int s = 0; s < 16; s++) begin
            logic [AW-1:0] sa = AW'(s * 32'h8000 + s * 7);
            unlock(); wr(19'h00555, 8'h80); unlock(); wr(sa, 8'h30);
            check("R3 start_sect", start_sect, 1);
            check("R3 sect addr", op_addr, sa);
            check("R12 onehot sect", {start_prog, start_chip}, 0);
        end

        // R4 upper address bits ignored for command cycles
        for (int k = 0; k < 8; k++) begin
            logic [7:0] up = 8'(k * 37 + 1);
            wr({up, 11'h555}, 8'hAA);
            wr({~up, 11'h2AA}, 8'h55);
            wr({up ^ 8'h5A, 11'h555}, 8'hA0);
            wr(19'h01234, 8'h66);
            check("R4 prog with upper bits", start_prog, 1);
        end

        // R5 corruption at each step, bad address and bad data
        for (int pos = 0; pos < 3; pos++) begin
            for (int kind = 0; kind < 2; kind++) begin
                logic [AW-1:0] ga [3];
                logic [7:0]    gd [3];
                ga[0] = 19'h00555; gd[0] = 8'hAA;
                ga[1] = 19'h002AA; gd[1] = 8'h55;
                ga[2] = 19'h00555; gd[2] = 8'hA0;
                if (kind == 0) ga[pos] = ga[pos] ^ 19'h00001;
                else           gd[pos] = 8'h77;
                for (int c = 0; c < 3; c++) begin
                    if (c == pos) wr(ga[c], gd[c]);
                    else if (c > pos) wr(ga[c], gd[c]);
                    else wr(ga[c], gd[c]);
                end
                wr(19'h00100, 8'h12);
                no_start("R5 corrupted sequence");
                check("R5 array mode", read_mode, 0);
            end
        end
        unlock(); wr(19'h00555, 8'hA0); wr(19'h00321, 8'hC3);
        check("R5 restart works", start_prog, 1);

        // R6 reset between cycles
        wr(19'h00555, 8'hAA); wr(19'h00000, 8'hF0);
        wr(19'h002AA, 8'h55); wr(19'h00555, 8'hA0); wr(19'h00100, 8'h12);
        no_start("R6 reset after first unlock");
        unlock(); wr(19'h00777, 8'hF0);
        wr(19'h00555, 8'hA0); wr(19'h00100, 8'h12);
        no_start("R6 reset after second unlock");
        unlock(); wr(19'h00555, 8'h80); unlock(); wr(19'h00000, 8'hF0);
        wr(19'h00555, 8'h10);
        no_start("R6 reset inside erase");
        check("R6 array", read_mode, 0);

        // R7 identification mode
        unlock(); wr(19'h00555, 8'h90);
        check("R7 mode", read_mode, 1);
        for (int sel = 0; sel < 4; sel++) begin
            for (int p = 0; p < 2; p++) begin
                logic [7:0] exp;
                id_sel = 2'(sel); sect_prot = p[0];
                exp = (sel == 0) ? MFR : (sel == 1) ? DEV : (sel == 2) ? {7'd0, p[0]} : 8'h00;
                #1;
                check("R7 id_data", id_data, exp);
            end
        end
        id_sel = 2'd0;
        wr(19'h00555, 8'hAA);
        check("R7 stays", read_mode, 1);
        wr(19'h00000, 8'hF0);
        check("R7 exit", read_mode, 0);
        check("R7 id quiet", id_data, 0);

        // R8 fast-program mode
        unlock(); wr(19'h00555, 8'h20);
        for (int i = 0; i < 3; i++) begin
            wr(19'h7FFFF, 8'hA0);
            wr(AW'(19'h00400 + i * 3), 8'(8'h90 + i));
            check("R8 bypass prog", start_prog, 1);
            check("R8 bypass data", op_data, 8'(8'h90 + i));
        end
        wr(19'h00555, 8'h80); wr(19'h00555, 8'h10);
        no_start("R8 erase ignored");
        wr(19'h00000, 8'hF0);
        wr(19'h00000, 8'hA0); wr(19'h00050, 8'h5E);
        check("R8 still bypass after F0", start_prog, 1);

        // R9 exit handling
        wr(19'h00000, 8'h90); wr(19'h00000, 8'h55);
        wr(19'h00000, 8'hA0); wr(19'h00051, 8'h5F);
        check("R9 90 then non-00 stays", start_prog, 1);
        wr(19'h00000, 8'h90); wr(19'h00000, 8'h00);
        wr(19'h00000, 8'hA0); wr(19'h00052, 8'h60);
        no_start("R9 exited");
        check("R9 array", read_mode, 0);

        // R10/R11 busy during sector erase
        unlock(); wr(19'h00555, 8'h80); unlock(); wr(19'h08000, 8'h30);
        check("R3 sect before busy", start_sect, 1);
        eng_busy = 1'b1; #1;
        check("R10 status mode", read_mode, 2);
        unlock(); wr(19'h00555, 8'hA0); wr(19'h00100, 8'h12);
        no_start("R10 busy ignores program");
        wr(19'h00000, 8'hB0);
        check("R11 suspend", suspend_req, 1);
        idle();
        check("R11 suspend ends", suspend_req, 0);
        eng_busy = 1'b0; idle();
        check("R10 back to array", read_mode, 0);

        // R11 no suspend during program
        unlock(); wr(19'h00555, 8'hA0); wr(19'h00100, 8'h12);
        eng_busy = 1'b1;
        wr(19'h00000, 8'hB0);
        check("R11 no suspend in program", suspend_req, 0);
        eng_busy = 1'b0; idle();
        // R11 no suspend during chip erase
        unlock(); wr(19'h00555, 8'h80); unlock(); wr(19'h00555, 8'h10);
        eng_busy = 1'b1;
        wr(19'h00000, 8'hB0);
        check("R11 no suspend in chip erase", suspend_req, 0);
        eng_busy = 1'b0; idle();

        // R10 state kept through busy
        unlock();
        eng_busy = 1'b1;
        wr(19'h00000, 8'hF0); wr(19'h00123, 8'h77);
        eng_busy = 1'b0;
        wr(19'h00555, 8'hA0); wr(19'h00200, 8'h21);
        check("R10 sequence kept", start_prog, 1);
        unlock(); wr(19'h00555, 8'h90);
        eng_busy = 1'b1;
        wr(19'h00000, 8'hF0);
        eng_busy = 1'b0; idle();
        check("R10 id mode kept", read_mode, 1);
        wr(19'h00000, 8'hF0);
        check("R10 id mode left", read_mode, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule